// File: doc/BRIEF.md
# CPU Bus Machine-Cycle Sequencer

This block generates the external bus timing of an 8-bit processor, one half-clock phase per tick of its clock input. A core asks for one machine cycle at a time. Each request gives a cycle kind, an address, write data, a variant code and a length. The sequencer then drives the address bus, the write data bus and the active-low memory request, I/O request, read, write, first-machine-cycle and refresh strobes for the exact number of phases that the kind and variant call for.

Each cycle has one point where the wait input is sampled. For most kinds that point is the last phase of a two-phase sample window. While wait is found low there, the window repeats for another two phases. Extra unsampled phases go before or after the window, depending on the variant. An opcode fetch is followed by a refresh interval of the requested length, during which the address bus carries a refresh address built from an interrupt-page register and a refresh counter. When a cycle ends, a one-clock done pulse appears, and for reading kinds the captured data bus value is held on rdata.

Top module: `bus_seq`

## Requirements
- R1: After reset, all six strobes are high, dout_oe, done and busy are low, and the refresh address is zero.
- R2: A memory read (req_kind 1) or write (req_kind 2) with req_ext 0 lasts 8 half-cycles. It has 3 start phases, a 2-phase sample window and 3 end phases. mreq_n and rd_n (read) or wr_n (write) are low in every phase except the first, and addr shows req_addr.
- R3: For memory kinds, req_ext 1 adds 2 unsampled phases before the sample window, req_ext 2 adds 2 after it, and req_ext 3 adds 4 before it. This gives 10, 10 and 12 half-cycles.
- R4: I/O input (req_kind 3) and output (req_kind 4) always have 2 unsampled phases between a 3-phase start and the sample window, then 3 end phases: 10 half-cycles in total. iorq_n and rd_n (input) or wr_n (output) are low in every phase but the first. mreq_n stays high.
- R5: An opcode fetch (req_kind 0) has 3 start phases, a 2-phase sample window and 1 latch phase. m1_n, mreq_n and rd_n are low throughout these phases, except that mreq_n and rd_n are high in the first phase. req_len refresh phases follow, where 0 counts as 1. In them rfsh_n and mreq_n are low and addr = {I, R}. rdata takes din from the latch phase.
- R6: ir_we loads I from ir_wdata[15:8] and R from ir_wdata[7:0]. Each completed fetch increments R[6:0], wrapping within 7 bits, and leaves R[7] unchanged.
- R7: An interrupt acknowledge (req_kind 5) starts with 5 phases when req_ext is 0 and 7 phases otherwise. It continues with a 2-phase sample window and 3 end phases. m1_n is low throughout, iorq_n is low in the window and end phases, and rdata takes din.
- R8: An internal cycle (req_kind 6 or 7) lasts req_len half-cycles, where 0 counts as 1. All strobes stay high and dout_oe stays low.
- R9: Each time wait_n is low at the sample point, the sample window repeats, adding 2 half-cycles. This continues until wait_n is high at the sample point.
- R10: A request is accepted when req_valid is high while busy is low. done is high for exactly the one clock after the final phase. Requests seen while busy are ignored, and addr holds the accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle phase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 3 | 0 fetch, 1 mem read, 2 mem write, 3 I/O in, 4 I/O out, 5 int ack, 6/7 internal |
| req_ext | input | 2 | Variant code (memory extra phases, int ack start length) |
| req_len | input | LW | Refresh length (fetch) or internal length |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| ir_we | input | 1 | Load I and R |
| ir_wdata | input | AW | New {I, R} value |
| wait_n | input | 1 | Active-low wait |
| din | input | DW | Data bus input |
| addr | output | AW | Address bus |
| dout | output | DW | Data bus output |
| dout_oe | output | 1 | Data bus output enable |
| mreq_n | output | 1 | Memory request strobe |
| iorq_n | output | 1 | I/O request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| m1_n | output | 1 | First machine cycle strobe |
| rfsh_n | output | 1 | Refresh strobe |
| rdata | output | DW | Captured read data |
| done | output | 1 | Cycle complete pulse |
| busy | output | 1 | Cycle in progress |

## Verification
Every kind is run with zero, one and two wait insertions, so a wrong repeat count shows up as a length error. The wait window is driven at the expected sample point for each memory variant. The pre-window and post-window variants then have the same total length only when the sample point is in the right place. Per-strobe phase counts separate which strobe goes low in which part of the cycle. The refresh counter is loaded near its 7-bit wrap so that a carry into bit 7 is caught. Seeded random mixes of kind, variant, length and wait count complete the coverage, and a request held through a cycle shows whether requests made while busy are ignored.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

   localparam logic [2:0] K_FETCH = 3'd0;
   localparam logic [2:0] K_MRD   = 3'd1;
   localparam logic [2:0] K_MWR   = 3'd2;
   localparam logic [2:0] K_IOIN  = 3'd3;
   localparam logic [2:0] K_IOOUT = 3'd4;
   localparam logic [2:0] K_INTA  = 3'd5;

   typedef enum logic [2:0] {
      S_IDLE, S_START, S_PRE, S_SAMP, S_POST, S_END, S_RFSH, S_HOLD
   } seg_e;

   function automatic logic is_mem(input logic [2:0] k);
      return (k == K_MRD) || (k == K_MWR);
   endfunction

   function automatic logic is_io(input logic [2:0] k);
      return (k == K_IOIN) || (k == K_IOOUT);
   endfunction

   function automatic logic is_internal(input logic [2:0] k);
      return k > K_INTA;
   endfunction

   function automatic logic reads_bus(input logic [2:0] k);
      return (k == K_FETCH) || (k == K_MRD) || (k == K_IOIN) || (k == K_INTA);
   endfunction

   function automatic logic [3:0] start_len(input logic [2:0] k, input logic [1:0] e);
      if (k == K_INTA) return (e == 2'd0) ? 4'd5 : 4'd7;
      return 4'd3;
   endfunction

   function automatic logic [3:0] pre_len(input logic [2:0] k, input logic [1:0] e);
      if (is_io(k)) return 4'd2;
      if (is_mem(k)) begin
         if (e == 2'd1) return 4'd2;
         if (e == 2'd3) return 4'd4;
      end
      return 4'd0;
   endfunction

   function automatic logic [3:0] post_len(input logic [2:0] k, input logic [1:0] e);
      if (is_mem(k) && e == 2'd2) return 4'd2;
      return 4'd0;
   endfunction

   function automatic logic [3:0] end_len(input logic [2:0] k);
      return (k == K_FETCH) ? 4'd1 : 4'd3;
   endfunction

endpackage

// File: rtl/bus_seq_timer.sv
module bus_seq_timer
   import bus_seq_pkg::*;
#(
   parameter int LW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    kind,
   input  logic [1:0]    ext,
   input  logic [LW-1:0] len,
   input  logic          wait_n,
   output seg_e          seg,
   output logic [2:0]    kind_q,
   output logic          lead,
   output logic          last,
   output logic          capture
);

   localparam int CW = (LW > 3) ? LW : 3;

   logic [CW-1:0] cnt;
   logic [1:0]    ext_q;
   logic [LW-1:0] len_q;
   logic [3:0]    pre_q, post_q;

   function automatic logic [CW-1:0] len_m1(input logic [LW-1:0] l);
      return (l == '0) ? '0 : CW'(l - 1'b1);
   endfunction

   function automatic logic [CW-1:0] ph_m1(input logic [3:0] l);
      return CW'(l - 4'd1);
   endfunction

   assign pre_q  = pre_len(kind_q, ext_q);
   assign post_q = post_len(kind_q, ext_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg    <= S_IDLE;
         cnt    <= '0;
         lead   <= 1'b0;
         kind_q <= '0;
         ext_q  <= '0;
         len_q  <= '0;
      end else begin
         lead <= 1'b0;
         if (seg == S_IDLE) begin
            if (start) begin
               kind_q <= kind;
               ext_q  <= ext;
               len_q  <= len;
               lead   <= 1'b1;
               if (is_internal(kind)) begin
                  seg <= S_HOLD;
                  cnt <= len_m1(len);
               end else begin
                  seg <= S_START;
                  cnt <= ph_m1(start_len(kind, ext));
               end
            end
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end else begin
            case (seg)
               S_START: begin
                  if (pre_q != 4'd0) begin
                     seg <= S_PRE;
                     cnt <= ph_m1(pre_q);
                  end else begin
                     seg <= S_SAMP;
                     cnt <= CW'(1);
                  end
               end
               S_PRE: begin
                  seg <= S_SAMP;
                  cnt <= CW'(1);
               end
               S_SAMP: begin
                  if (!wait_n) begin
                     cnt <= CW'(1);
                  end else if (post_q != 4'd0) begin
                     seg <= S_POST;
                     cnt <= ph_m1(post_q);
                  end else begin
                     seg <= S_END;
                     cnt <= ph_m1(end_len(kind_q));
                  end
               end
               S_POST: begin
                  seg <= S_END;
                  cnt <= ph_m1(end_len(kind_q));
               end
               S_END: begin
                  if (kind_q == K_FETCH) begin
                     seg <= S_RFSH;
                     cnt <= len_m1(len_q);
                  end else begin
                     seg <= S_IDLE;
                  end
               end
               default: seg <= S_IDLE;
            endcase
         end
      end
   end

   assign last = (cnt == '0) &&
                 ((seg == S_END && kind_q != K_FETCH) || seg == S_RFSH || seg == S_HOLD);
   assign capture = (seg == S_END) && (cnt == '0) && reads_bus(kind_q);

   // R9
   wait_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seg == S_SAMP && cnt == '0 && !wait_n) |=> (seg == S_SAMP && cnt == CW'(1)));

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seg != S_IDLE && seg != S_HOLD && kind_q != $past(kind_q)) |-> $past(seg == S_IDLE));

endmodule

// File: rtl/bus_seq_refresh.sv
module bus_seq_refresh #(
   parameter int AW  = 16,
   parameter int RW  = 8,
   parameter int RCW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] wdata,
   input  logic          step,
   output logic [AW-1:0] rfsh_addr
);

   localparam int IW = AW - RW;

   logic [IW-1:0] i_q;
   logic [RW-1:0] r_q, r_next;

   generate
      if (RCW >= RW) begin : g_full
         assign r_next = r_q + 1'b1;
      end else begin : g_split
         logic [RCW-1:0] low_inc;
         assign low_inc = r_q[RCW-1:0] + 1'b1;
         assign r_next  = {r_q[RW-1:RCW], low_inc};

         // R6
         r_top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !we) |=> (r_q[RW-1:RCW] == $past(r_q[RW-1:RCW]) && $stable(i_q)));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         i_q <= '0;
         r_q <= '0;
      end else if (we) begin
         i_q <= wdata[AW-1:RW];
         r_q <= wdata[RW-1:0];
      end else if (step) begin
         r_q <= r_next;
      end
   end

   assign rfsh_addr = {i_q, r_q};

endmodule

// File: rtl/bus_seq_strobe.sv
module bus_seq_strobe
   import bus_seq_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  seg_e          seg,
   input  logic          lead,
   input  logic [2:0]    kind_q,
   input  logic [AW-1:0] addr_q,
   input  logic [DW-1:0] wdata_q,
   input  logic [AW-1:0] rfsh_addr,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] dout,
   output logic          dout_oe,
   output logic          mreq_n,
   output logic          iorq_n,
   output logic          rd_n,
   output logic          wr_n,
   output logic          m1_n,
   output logic          rfsh_n
);

   logic main, body, refr, wr_kind, rd_kind;

   always_comb begin
      main    = (seg == S_START) || (seg == S_PRE) || (seg == S_SAMP) ||
                (seg == S_POST)  || (seg == S_END);
      body    = main && !lead;
      refr    = (seg == S_RFSH);
      wr_kind = (kind_q == K_MWR) || (kind_q == K_IOOUT);
      rd_kind = (kind_q == K_FETCH) || (kind_q == K_MRD) || (kind_q == K_IOIN);

      addr    = refr ? rfsh_addr : addr_q;
      dout    = wdata_q;
      dout_oe = main && wr_kind;
      mreq_n  = !((body && (kind_q == K_FETCH || is_mem(kind_q))) || refr);
      rd_n    = !(body && rd_kind);
      wr_n    = !(body && wr_kind);
      iorq_n  = !((body && is_io(kind_q)) ||
                  (kind_q == K_INTA && (seg == S_SAMP || seg == S_END)));
      m1_n    = !(main && (kind_q == K_FETCH || kind_q == K_INTA));
      rfsh_n  = !refr;
   end

endmodule

// File: rtl/bus_seq.sv
module bus_seq
   import bus_seq_pkg::*;
#(
   parameter int AW  = 16,
   parameter int DW  = 8,
   parameter int LW  = 4,
   parameter int RCW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    req_kind,
   input  logic [1:0]    req_ext,
   input  logic [LW-1:0] req_len,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          ir_we,
   input  logic [AW-1:0] ir_wdata,
   input  logic          wait_n,
   input  logic [DW-1:0] din,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] dout,
   output logic          dout_oe,
   output logic          mreq_n,
   output logic          iorq_n,
   output logic          rd_n,
   output logic          wr_n,
   output logic          m1_n,
   output logic          rfsh_n,
   output logic [DW-1:0] rdata,
   output logic          done,
   output logic          busy
);

   generate
      if (AW <= DW) begin : g_bad_aw
         $error("bus_seq: AW must exceed DW");
      end
      if (LW < 1 || LW > 16) begin : g_bad_lw
         $error("bus_seq: LW out of range");
      end
      if (RCW < 1 || RCW > DW) begin : g_bad_rcw
         $error("bus_seq: RCW out of range");
      end
   endgenerate

   seg_e          seg;
   logic [2:0]    kind_q;
   logic          lead, last, capture, start;
   logic [AW-1:0] addr_q, rfsh_addr;
   logic [DW-1:0] wdata_q;

   assign busy  = (seg != S_IDLE);
   assign start = req_valid && !busy;

   bus_seq_timer #(.LW(LW)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(req_kind), .ext(req_ext),
      .len(req_len), .wait_n(wait_n), .seg(seg), .kind_q(kind_q), .lead(lead),
      .last(last), .capture(capture)
   );

   bus_seq_refresh #(.AW(AW), .RW(DW), .RCW(RCW)) u_refresh (
      .clk(clk), .rst_n(rst_n), .we(ir_we), .wdata(ir_wdata),
      .step(last && seg == S_RFSH), .rfsh_addr(rfsh_addr)
   );

   bus_seq_strobe #(.AW(AW), .DW(DW)) u_strobe (
      .seg(seg), .lead(lead), .kind_q(kind_q), .addr_q(addr_q), .wdata_q(wdata_q),
      .rfsh_addr(rfsh_addr), .addr(addr), .dout(dout), .dout_oe(dout_oe),
      .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
      .rfsh_n(rfsh_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata   <= '0;
         done    <= 1'b0;
      end else begin
         done <= last;
         if (start) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (capture) rdata <= din;
      end
   end

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && rfsh_n && $past(rfsh_n)) |-> $stable(addr));

   // R5
   rfsh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rfsh_n |-> (!mreq_n && rd_n && wr_n && m1_n && iorq_n));

   // R2
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (wr_n && !dout_oe));

   // R8
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seg == S_HOLD) |-> (mreq_n && iorq_n && rd_n && wr_n && m1_n && rfsh_n && !dout_oe));

endmodule

// File: tb/tb_bus_seq.sv
module tb_bus_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = '0;
   logic [1:0]  req_ext = '0;
   logic [3:0]  req_len = '0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        ir_we = 1'b0;
   logic [15:0] ir_wdata = '0;
   logic        wait_n = 1'b1;
   logic [7:0]  din = '0;
   logic [15:0] addr;
   logic [7:0]  dout, rdata;
   logic        dout_oe, mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, done, busy;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   logic [7:0] m_i = 8'h00;
   logic [7:0] m_r = 8'h00;

   bus_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_ext(req_ext), .req_len(req_len), .req_addr(req_addr), .req_wdata(req_wdata),
      .ir_we(ir_we), .ir_wdata(ir_wdata), .wait_n(wait_n), .din(din),
      .addr(addr), .dout(dout), .dout_oe(dout_oe), .mreq_n(mreq_n), .iorq_n(iorq_n),
      .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n), .rdata(rdata),
      .done(done), .busy(busy)
   );

   always #4 clk = ~clk;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int f_start(input int k, input int e);
      return (k == 5) ? ((e == 0) ? 5 : 7) : 3;
   endfunction
   function automatic int f_pre(input int k, input int e);
      if (k == 3 || k == 4) return 2;
      if (k == 1 || k == 2) return (e == 1) ? 2 : (e == 3) ? 4 : 0;
      return 0;
   endfunction
   function automatic int f_post(input int k, input int e);
      return ((k == 1 || k == 2) && e == 2) ? 2 : 0;
   endfunction
   function automatic int f_main(input int k, input int e, input int w);
      return f_start(k, e) + f_pre(k, e) + 2 + 2 * w + f_post(k, e) + ((k == 0) ? 1 : 3);
   endfunction
   function automatic int f_len(input int l);
      return (l == 0) ? 1 : l;
   endfunction
   function automatic string tag_of(input int k);
      case (k)
         0: return "R5";
         1, 2: return "R2";
         3, 4: return "R4";
         5: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic load_ir(input logic [15:0] v);
      @(negedge clk);
      ir_we = 1'b1;
      ir_wdata = v;
      @(negedge clk);
      ir_we = 1'b0;
      m_i = v[15:8];
      m_r = v[7:0];
   endtask

   task automatic run(input int k, input int e, input int l, input logic [15:0] a,
                      input logic [7:0] wd, input int nw, input logic [7:0] dv,
                      input bit hold_req, input string wtag);
      int t, s, total, mainl;
      int c_mreq, c_iorq, c_rd, c_wr, c_m1, c_rf, bad_ra, bad_a, bad_d;
      string tg;
      bit internal;
      internal = (k >= 6);
      tg = tag_of(k);
      mainl = internal ? 0 : f_main(k, e, nw);
      total = internal ? f_len(l) : mainl + ((k == 0) ? f_len(l) : 0);
      s = f_start(k, e) + f_pre(k, e) + 1;
      c_mreq = 0; c_iorq = 0; c_rd = 0; c_wr = 0; c_m1 = 0; c_rf = 0;
      bad_ra = 0; bad_a = 0; bad_d = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_kind = 3'(k);
      req_ext = 2'(e);
      req_len = 4'(l);
      req_addr = a;
      req_wdata = wd;
      din = dv;
      wait_n = 1'b1;
      @(posedge clk);
      t = 0;
      forever begin
         @(negedge clk);
         if (!hold_req || t >= 2) req_valid = 1'b0;
         else begin
            req_addr = ~a;
            req_kind = 3'd2;
         end
         if (done) break;
         if (!mreq_n) c_mreq++;
         if (!iorq_n) c_iorq++;
         if (!rd_n) c_rd++;
         if (!wr_n) c_wr++;
         if (!m1_n) c_m1++;
         if (!rfsh_n) begin
            c_rf++;
            if (addr != {m_i, m_r}) bad_ra++;
         end else if (addr != a) bad_a++;
         if (dout_oe && dout != wd) bad_d++;
         wait_n = internal ? 1'b1 : !(t >= s && t < s + 2 * nw);
         t++;
         if (t > 200) break;
      end
      wait_n = 1'b1;
      check({tg, " length"}, t, total);
      check({wtag, " length with waits"}, t, total);
      check("R10 addr held", bad_a, 0);
      check({tg, " mreq_n count"}, c_mreq,
            (k == 0) ? mainl - 1 + f_len(l) : (k == 1 || k == 2) ? mainl - 1 : 0);
      check({tg, " iorq_n count"}, c_iorq,
            (k == 3 || k == 4) ? mainl - 1 : (k == 5) ? 5 + 2 * nw : 0);
      check({tg, " rd_n count"}, c_rd, (k == 0 || k == 1 || k == 3) ? mainl - 1 : 0);
      check({tg, " wr_n count"}, c_wr, (k == 2 || k == 4) ? mainl - 1 : 0);
      check({tg, " m1_n count"}, c_m1, (k == 0 || k == 5) ? mainl : 0);
      check("R5 rfsh_n count", c_rf, (k == 0) ? f_len(l) : 0);
      check("R6 refresh address", bad_ra, 0);
      check({tg, " dout value"}, bad_d, 0);
      if (k == 0 || k == 1 || k == 3 || k == 5)
         check({tg, " rdata"}, int'(rdata), int'(dv));
      @(negedge clk);
      check("R10 done single pulse", int'(done), 0);
      if (k == 0) m_r = {m_r[7], m_r[6:0] + 7'd1};
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 12345;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 strobes", int'({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n}), 63);
      check("R1 busy/done/oe", int'({busy, done, dout_oe}), 0);
      check("R1 refresh addr", int'(dut.addr), 0);

      // R2 standard read and write
      run(1, 0, 0, 16'h1234, 8'h00, 0, 8'hA5, 0, "R2");
      run(2, 0, 0, 16'h4321, 8'h5A, 0, 8'h00, 0, "R2");
      // R3 variants with one wait each (sample point placement)
      run(1, 1, 0, 16'h2000, 8'h00, 1, 8'h11, 0, "R3");
      run(1, 2, 0, 16'h2001, 8'h00, 1, 8'h22, 0, "R3");
      run(1, 3, 0, 16'h2002, 8'h00, 1, 8'h33, 0, "R3");
      run(2, 3, 0, 16'h2003, 8'h44, 0, 8'h00, 0, "R3");
      // R4 I/O
      run(3, 0, 0, 16'h00FE, 8'h00, 0, 8'h7E, 0, "R4");
      run(4, 2, 0, 16'h00FD, 8'hC3, 1, 8'h00, 0, "R4");
      // R5/R6 fetch with refresh lengths, counter wrap
      load_ir(16'h3F7E);
      run(0, 0, 4, 16'h0100, 8'h00, 0, 8'h3E, 0, "R5");
      run(0, 0, 6, 16'h0101, 8'h00, 1, 8'h01, 0, "R5");
      run(0, 0, 8, 16'h0102, 8'h00, 0, 8'hED, 0, "R6");
      load_ir(16'h80FF);
      run(0, 0, 4, 16'h0103, 8'h00, 0, 8'h00, 0, "R6");
      run(0, 0, 4, 16'h0104, 8'h00, 0, 8'h76, 0, "R6");
      // R7 interrupt acknowledge
      run(5, 0, 0, 16'h0000, 8'h00, 0, 8'hFF, 0, "R7");
      run(5, 1, 0, 16'h0000, 8'h00, 1, 8'hCF, 0, "R7");
      // R8 internal
      run(6, 0, 0, 16'h0000, 8'h00, 0, 8'h00, 0, "R8");
      run(7, 0, 5, 16'h0000, 8'h00, 0, 8'h00, 0, "R8");
      // R9 two waits
      run(1, 0, 0, 16'hBEEF, 8'h00, 2, 8'h99, 0, "R9");
      // R10 request held while busy
      run(1, 0, 0, 16'h5555, 8'h00, 0, 8'h66, 1, "R10");

      for (int i = 0; i < 40; i++) begin
         int k, e, l, w;
         k = int'($urandom % 8);
         e = int'($urandom % 4);
         l = int'($urandom % 9);
         w = int'($urandom % 3);
         run(k, e, l, 16'($urandom), 8'($urandom), w, 8'($urandom), 0, "R9");
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule